// File: doc/BRIEF.md
# Block-Mode DMA Transfer Sequencer

This block is one DMA channel that copies memory in whole blocks of 16-bit words. Both the source address and the destination address are programmable, and the channel drives both of them itself. Software-facing registers are modelled as plain configuration inputs: two start addresses, a step-enable bit for each side, a block length in words and a count of blocks. A one-cycle load strobe copies these inputs into the channel. While that count is non-zero, the channel is armed.

A transfer request makes the channel ask for the bus. Once the bus is granted, the channel copies exactly one block. For each word it runs a read cycle on the source, and the cycle after that it runs a write cycle on the destination. Nothing can break the chain of word moves once the block has started. When the block ends, the channel spends one idle dead cycle while still holding the bus, and then it drops its bus request. The channel does not ask for the bus again until the CPU has used the bus for at least one cycle. A request that arrives while a block is running, or while the bus is released, is remembered and served later.

Top module: `blkdma_seq`

## Requirements
- R1: After reset `bus_req`, `mem_rd`, `mem_wr` and `active` are low. A `cfg_load` pulse loads the configuration, and `active` then equals (`cfg_xfer_cnt` != 0).
- R2: Each word is a read cycle (`mem_rd` high for one clock, `mem_addr` = source address) followed at once by a write cycle (`mem_wr` high for one clock, `mem_addr` = destination address). During the write cycle, `mem_wdata` equals the `mem_rdata` value sampled in the read cycle.
- R3: Within a block, the read of each following word comes in the cycle right after the previous write. Neither `dreq` nor `bus_gnt` changes this while the block runs. A `dreq` seen during a block is latched for a later block.
- R4: One request moves exactly `cfg_blk_size` words. A size of 0 means 2^BLK_W words (256 by default).
- R5: In the cycle after the final write of every block, the channel keeps `bus_req` high and keeps both strobes low (the dead cycle).
- R6: In the cycle after the dead cycle, `bus_req` is low. It stays low until a `cpu_cycle` pulse has been seen while `bus_req` is low. A pending request is then served.
- R7: After each word, the source address grows by 2 when `cfg_src_inc` is 1 and holds when it is 0. The destination address follows `cfg_dst_inc` in the same way.
- R8: The block count drops by one per finished block. When it reaches zero, `active` falls and later `dreq` pulses never raise `bus_req`.
- R9: After raising `bus_req`, the channel issues no read until `bus_gnt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load-configuration strobe |
| cfg_src_addr | input | 24 | Source start byte address |
| cfg_dst_addr | input | 24 | Destination start byte address |
| cfg_src_inc | input | 1 | 1: source steps by 2 per word, 0: holds |
| cfg_dst_inc | input | 1 | 1: destination steps by 2 per word, 0: holds |
| cfg_blk_size | input | 8 | Words per block (0 = 256) |
| cfg_xfer_cnt | input | 16 | Number of blocks |
| dreq | input | 1 | Transfer request pulse |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| cpu_cycle | input | 1 | CPU performed a bus cycle this clock |
| mem_addr | output | 24 | Bus address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 16 | Read data, valid during the read cycle |
| mem_wdata | output | 16 | Write data |
| active | output | 1 | Channel has blocks left to move |

## Verification
The hardest state to reach is a request that is already pending when a block ends. The channel must then hold back at the release point even though a request is waiting, because the CPU has not yet used the bus. The bench reaches this state in two ways. In the first, it raises `dreq` and removes the grant in the middle of a block. In the second, it pulses `dreq` during the release cycle. In both cases it keeps `cpu_cycle` low for several clocks, checks that `bus_req` stays low, and only then pulses `cpu_cycle` and checks the next block. A 256-word block that starts at a source address just below a 32 KiB boundary covers the case where a block size of 0 means the full count.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARB  = 3'd1,
    ST_RD   = 3'd2,
    ST_WR   = 3'd3,
    ST_DEAD = 3'd4,
    ST_REL  = 3'd5
  } dma_state_t;

  localparam int WORD_BITS  = 16;
  localparam int WORD_BYTES = WORD_BITS / 8;
endpackage

// File: rtl/blkdma_addr_gen.sv
module blkdma_addr_gen #(
  parameter int ADDR_W = 24,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic              inc_en_in,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic inc_en;

  function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] a,
                                                input logic inc);
    return inc ? a + STEP_V : a;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      inc_en <= 1'b0;
    end else if (load) begin
      addr   <= init_addr;
      inc_en <= inc_en_in;
    end else if (step) begin
      addr <= advance(addr, inc_en);
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !inc_en) |=> $stable(addr));
endmodule

// File: rtl/blkdma_counters.sv
module blkdma_counters #(
  parameter int BLK_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [BLK_W-1:0] cfg_blk_size,
  input  logic [CNT_W-1:0] cfg_xfer_cnt,
  input  logic             blk_start,
  input  logic             unit_done,
  output logic             last_unit,
  output logic             blk_done,
  output logic             active
);
  localparam logic [BLK_W-1:0] ONE_U = BLK_W'(1);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [BLK_W-1:0] blk_size_r;
  logic [BLK_W-1:0] unit_cnt;
  logic [CNT_W-1:0] xfer_cnt;

  assign last_unit = (unit_cnt == ONE_U);
  assign blk_done  = unit_done && last_unit;
  assign active    = (xfer_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_size_r <= '0;
      unit_cnt   <= '0;
      xfer_cnt   <= '0;
    end else if (cfg_load) begin
      blk_size_r <= cfg_blk_size;
      unit_cnt   <= cfg_blk_size;
      xfer_cnt   <= cfg_xfer_cnt;
    end else begin
      if (blk_start)
        unit_cnt <= blk_size_r;
      else if (unit_done)
        unit_cnt <= unit_cnt - ONE_U;
      if (blk_done)
        xfer_cnt <= xfer_cnt - ONE_C;
    end
  end

  assert_block_dec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && !cfg_load) |=> (xfer_cnt == $past(xfer_cnt) - ONE_C));
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_start && !cfg_load) |=> (unit_cnt == blk_size_r));
endmodule

// File: rtl/blkdma_fsm.sv
module blkdma_fsm
  import blkdma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_load,
  input  logic dreq,
  input  logic bus_gnt,
  input  logic cpu_cycle,
  input  logic active,
  input  logic last_unit,
  output logic bus_req,
  output logic rd_cyc,
  output logic wr_cyc,
  output logic dead_cyc,
  output logic blk_start,
  output logic unit_done
);
  dma_state_t state, nxt;
  logic pend;
  logic cpu_ok;

  assign bus_req   = (state == ST_ARB) || (state == ST_RD) ||
                     (state == ST_WR)  || (state == ST_DEAD);
  assign rd_cyc    = (state == ST_RD);
  assign wr_cyc    = (state == ST_WR);
  assign dead_cyc  = (state == ST_DEAD);
  assign blk_start = (state == ST_ARB) && bus_gnt;
  assign unit_done = wr_cyc;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (active && pend && cpu_ok) nxt = ST_ARB;
      ST_ARB:  if (bus_gnt) nxt = ST_RD;
      ST_RD:   nxt = ST_WR;
      ST_WR:   nxt = last_unit ? ST_DEAD : ST_RD;
      ST_DEAD: nxt = ST_REL;
      ST_REL:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pend   <= 1'b0;
      cpu_ok <= 1'b1;
    end else begin
      state <= nxt;
      if (cfg_load)
        pend <= 1'b0;
      else if (dreq && active)
        pend <= 1'b1;
      else if (blk_start)
        pend <= 1'b0;
      if (cfg_load)
        cpu_ok <= 1'b1;
      else if (state == ST_DEAD)
        cpu_ok <= 1'b0;
      else if (cpu_cycle && !bus_req)
        cpu_ok <= 1'b1;
    end
  end

  assert_rd_then_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cyc |=> wr_cyc);
  assert_no_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_cyc && wr_cyc));
  assert_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && !last_unit) |=> rd_cyc);
  assert_dead_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && last_unit) |=> (dead_cyc && bus_req && !rd_cyc && !wr_cyc));
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dead_cyc |=> !bus_req);
  assert_wait_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !rd_cyc && !wr_cyc && !dead_cyc && !bus_gnt) |=> !rd_cyc);
endmodule

// File: rtl/blkdma_seq.sv
module blkdma_seq
  import blkdma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BLK_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  logic [ADDR_W-1:0]    cfg_src_addr,
  input  logic [ADDR_W-1:0]    cfg_dst_addr,
  input  logic                 cfg_src_inc,
  input  logic                 cfg_dst_inc,
  input  logic [BLK_W-1:0]     cfg_blk_size,
  input  logic [CNT_W-1:0]     cfg_xfer_cnt,
  input  logic                 dreq,
  output logic                 bus_req,
  input  logic                 bus_gnt,
  input  logic                 cpu_cycle,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_rd,
  output logic                 mem_wr,
  input  logic [WORD_BITS-1:0] mem_rdata,
  output logic [WORD_BITS-1:0] mem_wdata,
  output logic                 active
);
  logic rd_cyc, wr_cyc, dead_cyc, blk_start, unit_done, last_unit, blk_done;
  logic [ADDR_W-1:0]    src_addr, dst_addr;
  logic [WORD_BITS-1:0] data_r;

  blkdma_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .dreq(dreq),
    .bus_gnt(bus_gnt), .cpu_cycle(cpu_cycle), .active(active),
    .last_unit(last_unit), .bus_req(bus_req), .rd_cyc(rd_cyc),
    .wr_cyc(wr_cyc), .dead_cyc(dead_cyc), .blk_start(blk_start),
    .unit_done(unit_done)
  );

  blkdma_counters #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_blk_size(cfg_blk_size), .cfg_xfer_cnt(cfg_xfer_cnt),
    .blk_start(blk_start), .unit_done(unit_done), .last_unit(last_unit),
    .blk_done(blk_done), .active(active)
  );

  blkdma_addr_gen #(.ADDR_W(ADDR_W), .STEP(WORD_BYTES)) u_src (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .init_addr(cfg_src_addr),
    .inc_en_in(cfg_src_inc), .step(rd_cyc), .addr(src_addr)
  );

  blkdma_addr_gen #(.ADDR_W(ADDR_W), .STEP(WORD_BYTES)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .init_addr(cfg_dst_addr),
    .inc_en_in(cfg_dst_inc), .step(wr_cyc), .addr(dst_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      data_r <= '0;
    else if (rd_cyc)
      data_r <= mem_rdata;
  end

  assign mem_rd    = rd_cyc;
  assign mem_wr    = wr_cyc;
  assign mem_addr  = wr_cyc ? dst_addr : src_addr;
  assign mem_wdata = data_r;

  assert_wdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (mem_wdata == $past(mem_rdata)));
  assert_strobe_owns_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> bus_req);
  assert_block_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && !cfg_load) |=> dead_cyc);
endmodule

// File: tb/blkdma_seq_test.sv
module blkdma_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load;
  logic [23:0] cfg_src_addr, cfg_dst_addr;
  logic        cfg_src_inc, cfg_dst_inc;
  logic [7:0]  cfg_blk_size;
  logic [15:0] cfg_xfer_cnt;
  logic        dreq, bus_req, bus_gnt, cpu_cycle, gnt_en;
  logic [23:0] mem_addr;
  logic        mem_rd, mem_wr, active;
  logic [15:0] mem_rdata, mem_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] src_word(input logic [23:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[23:16], 8'h00};
  endfunction

  assign mem_rdata = src_word(mem_addr);
  assign bus_gnt   = bus_req & gnt_en;

  blkdma_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_src_addr(cfg_src_addr),
    .cfg_dst_addr(cfg_dst_addr), .cfg_src_inc(cfg_src_inc),
    .cfg_dst_inc(cfg_dst_inc), .cfg_blk_size(cfg_blk_size),
    .cfg_xfer_cnt(cfg_xfer_cnt), .dreq(dreq), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .cpu_cycle(cpu_cycle), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .active(active)
  );

  localparam int NV = 4;
  localparam logic [23:0] V_SRC [NV] = '{24'h001000, 24'h003000, 24'h005000, 24'h007FFE};
  localparam logic [23:0] V_DST [NV] = '{24'h002000, 24'h004000, 24'h006000, 24'h00A000};
  localparam bit          V_SI  [NV] = '{1'b1, 1'b0, 1'b1, 1'b1};
  localparam bit          V_DI  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [7:0]  V_BSZ [NV] = '{8'd3, 8'd4, 8'd1, 8'd0};
  localparam logic [15:0] V_CNT [NV] = '{16'd2, 16'd1, 16'd3, 16'd1};

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [23:0] s, input logic [23:0] d, input bit si,
                          input bit di, input logic [7:0] bsz, input logic [15:0] cnt);
    @(negedge clk);
    cfg_src_addr = s; cfg_dst_addr = d; cfg_src_inc = si; cfg_dst_inc = di;
    cfg_blk_size = bsz; cfg_xfer_cnt = cnt; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic pulse_dreq();
    dreq = 1'b1;
    @(negedge clk);
    dreq = 1'b0;
  endtask

  task automatic pulse_cpu();
    cpu_cycle = 1'b1;
    @(negedge clk);
    cpu_cycle = 1'b0;
  endtask

  // Walks one block at negedges; optionally disturbs dreq and the grant mid-block (R3)
  task automatic run_block(input logic [23:0] s0, input logic [23:0] d0, input bit si,
                           input bit di, input int n, input bit disturb,
                           output logic [23:0] s1, output logic [23:0] d1);
    logic [23:0] s, d;
    bit ok;
    s = s0; d = d0;
    for (int k = 0; k < 200 && !mem_rd; k++) @(negedge clk);
    chk(mem_rd, "R9 block start after grant", 32'(mem_rd), 1);
    for (int u = 0; u < n; u++) begin
      chk(mem_rd && mem_addr == s, "R7 read address", 32'(mem_addr), 32'(s));
      if (disturb && u == 0) begin dreq = 1'b1; gnt_en = 1'b0; end
      @(negedge clk);
      dreq = 1'b0;
      ok = mem_wr && !mem_rd && mem_addr == d;
      chk(ok, "R2 write cycle address", 32'(mem_addr), 32'(d));
      chk(mem_wdata == src_word(s), "R2 write data", 32'(mem_wdata), 32'(src_word(s)));
      if (si) s = s + 24'd2;
      if (di) d = d + 24'd2;
      @(negedge clk);
      if (u != n - 1)
        chk(mem_rd, "R3 next read follows write", 32'(mem_rd), 1);
    end
    ok = bus_req && !mem_rd && !mem_wr;
    chk(ok, "R5 dead cycle / R4 block length", {29'd0, bus_req, mem_rd, mem_wr}, 32'h4);
    @(negedge clk);
    chk(!bus_req, "R6 release after dead cycle", 32'(bus_req), 0);
    gnt_en = 1'b1;
    s1 = s; d1 = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] s, d, s2, d2;
    rst_n = 1'b0; cfg_load = 1'b0; dreq = 1'b0; cpu_cycle = 1'b0; gnt_en = 1'b1;
    cfg_src_addr = '0; cfg_dst_addr = '0; cfg_src_inc = 1'b0; cfg_dst_inc = 1'b0;
    cfg_blk_size = '0; cfg_xfer_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && !mem_rd && !mem_wr && !active, "R1 reset state",
        {28'd0, bus_req, mem_rd, mem_wr, active}, 0);

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      load_cfg(V_SRC[v], V_DST[v], V_SI[v], V_DI[v], V_BSZ[v], V_CNT[v]);
      chk(active == 1'b1, "R1 active after load", 32'(active), 1);
      s = V_SRC[v]; d = V_DST[v];
      for (int b = 0; b < int'(V_CNT[v]); b++) begin
        pulse_cpu();
        pulse_dreq();
        run_block(s, d, V_SI[v], V_DI[v], (V_BSZ[v] == 0) ? 256 : int'(V_BSZ[v]),
                  1'b0, s2, d2);
        s = s2; d = d2;
      end
      chk(!active, "R8 inactive after last block", 32'(active), 0);
    end

    // R8: request ignored once the count is spent
    pulse_dreq();
    repeat (10) @(negedge clk);
    chk(!bus_req && !mem_rd, "R8 spent channel ignores dreq", 32'(bus_req), 0);

    // R1: zero block count leaves the channel idle
    load_cfg(24'h000100, 24'h000200, 1'b1, 1'b1, 8'd2, 16'd0);
    chk(!active, "R1 zero count inactive", 32'(active), 0);
    pulse_dreq();
    repeat (6) @(negedge clk);
    chk(!bus_req, "R1 zero count no bus request", 32'(bus_req), 0);

    // R9: withheld grant stalls before the first read
    load_cfg(24'h000400, 24'h000800, 1'b1, 1'b1, 8'd2, 16'd3);
    gnt_en = 1'b0;
    pulse_dreq();
    repeat (4) @(negedge clk);
    chk(bus_req && !mem_rd, "R9 request held without read", {30'd0, bus_req, mem_rd}, 32'h2);
    repeat (6) @(negedge clk);
    chk(!mem_rd && !mem_wr, "R9 no strobe without grant", {30'd0, mem_rd, mem_wr}, 0);
    gnt_en = 1'b1;
    // R3: dreq and grant loss mid-block do not break the block; dreq latched
    run_block(24'h000400, 24'h000800, 1'b1, 1'b1, 2, 1'b1, s, d);

    // R6: pending request waits for a CPU cycle
    repeat (8) @(negedge clk);
    chk(!bus_req, "R6 pending request gated by CPU cycle", 32'(bus_req), 0);
    pulse_cpu();
    run_block(s, d, 1'b1, 1'b1, 2, 1'b0, s2, d2);

    // R6: request during release, again gated
    pulse_dreq();
    repeat (5) @(negedge clk);
    chk(!bus_req, "R6 release-time request gated", 32'(bus_req), 0);
    pulse_cpu();
    run_block(s2, d2, 1'b1, 1'b1, 2, 1'b0, s, d);
    chk(!active, "R8 count exhausted after three blocks", 32'(active), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule